// File: doc/BRIEF.md
# Prefix-Accumulating Instruction Decoder

This block turns a byte stream of instructions for a compact stack machine into decoded records. Each byte holds a 4-bit function code in its upper half and a 4-bit data nibble in its lower half. An internal 32-bit operand register collects nibbles. Two prefix functions, one positive and one negative, widen the register across several bytes and emit nothing. Any other byte completes an instruction. It emits one record with its function code and the full operand, and then clears the register. A prefix chain can therefore give the next instruction a wide positive or a negative immediate.

For the operate function, the operand picks a secondary operation. The record then also carries an 8-bit secondary code and an illegal flag. Bytes enter on a valid/ready port, and records leave on a valid/ready port through a single holding register. A byte is taken in the cycle where `in_valid` and `in_ready` are both high. A record is taken in the cycle where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the holding register is empty or is being emptied in that same cycle. A stalled consumer therefore stalls the input one cycle later. With `out_ready` held high, one byte passes per cycle.

Top module: `nib_prefix_decoder`

## Requirements
- R1: Bits [7:4] of an accepted byte are its function code, and bits [3:0] are its data nibble. The record's function field equals bits [7:4] of the completing byte.
- R2: A non-prefix byte with no prefix before it since the last record (or since reset) gives the operand nibble zero-extended to 32 bits.
- R3: An accepted byte with function 0x2 (positive prefix) sets O = (O | n) << 4 and emits no record.
- R4: An accepted byte with function 0x6 (negative prefix) sets O = ~(O | n) << 4 and emits no record.
- R5: An accepted byte with any other function emits exactly one record with operand O | n, and O returns to zero.
- R6: For function 0xF, the record has is_opr = 1 and a secondary code equal to operand bits [7:0]. The illegal flag is 1 if operand bits [31:8] are nonzero. It is also 1 if the code lies outside the supported set. The supported set is 0x00–0x10, 0x13, 0x16, 0x19–0x1B, 0x1D, 0x1F–0x28, 0x2B–0x2C, 0x2E–0x33, 0x35–0x39, 0x3B–0x3C, 0x3E, 0x40–0x4F, 0x51–0x53, 0x55–0x56, 0x72, 0x79, 0xAD–0xAE and 0xB0–0xB3. For every other function, is_opr, the secondary code and the illegal flag are all zero.
- R7: `in_ready` = !out_valid || out_ready. While out_valid is high and out_ready is low, the record stays unchanged in the next cycle.
- R8: A byte on `in_byte` while `in_valid` is low changes neither the operand register nor the output.
- R9: Synchronous reset clears the operand register and drops any pending record (out_valid = 0).
- R10: With out_ready held high, a byte is accepted every cycle, and each record appears one cycle after its completing byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction byte is offered |
| in_ready | output | 1 | Decoder takes the offered byte this cycle |
| in_byte | input | 8 | Instruction byte |
| out_valid | output | 1 | Decoded record is available |
| out_ready | input | 1 | Consumer takes the record this cycle |
| out_func | output | 4 | Primary function code |
| out_operand | output | 32 | Accumulated operand |
| out_is_opr | output | 1 | Record is an operate instruction |
| out_sec_code | output | 8 | Secondary operation code (operate only) |
| out_sec_illegal | output | 1 | Secondary code outside the supported set or operand too wide |

## Verification
Single-byte instructions with no prefix show the nibble placement and show that the register is cleared between records. Chains of positive prefixes, negative prefixes and mixed prefixes show whether each prefix merges its nibble before shifting, and whether inversion covers the whole register. Operate bytes are sent with supported codes, with codes that are gaps in the set, and with operands wider than a byte, to separate the code-table check from the width check. Idle cycles carrying junk bytes, random back-pressure and a reset that falls between a prefix and its instruction show that stalls, idle bytes and reset each leave the operand state alone or clear it as required.

// File: rtl/nibdec_pkg.sv
`timescale 1ns/1ps
package nibdec_pkg;

  localparam int FN_W   = 4;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = FN_W + NIB_W;

  localparam logic [FN_W-1:0] FN_POS_PREFIX = 4'h2;
  localparam logic [FN_W-1:0] FN_NEG_PREFIX = 4'h6;
  localparam logic [FN_W-1:0] FN_OPERATE    = 4'hF;

  typedef enum logic [1:0] {
    BK_PLAIN   = 2'd0,
    BK_POS_PFX = 2'd1,
    BK_NEG_PFX = 2'd2
  } byte_kind_e;

  // Secondary operations that the execution side implements.
  function automatic logic sec_supported(input logic [7:0] code);
    return code inside {
      [8'h00:8'h10], 8'h13, 8'h16, [8'h19:8'h1B], 8'h1D,
      [8'h1F:8'h28], [8'h2B:8'h2C], [8'h2E:8'h33], [8'h35:8'h39],
      [8'h3B:8'h3C], 8'h3E, [8'h40:8'h4F], [8'h51:8'h53],
      [8'h55:8'h56], 8'h72, 8'h79, [8'hAD:8'hAE], [8'hB0:8'hB3]
    };
  endfunction

endpackage

// File: rtl/nibdec_split.sv
`timescale 1ns/1ps
module nibdec_split
  import nibdec_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_in,
  output logic [FN_W-1:0]   func,
  output logic [NIB_W-1:0]  nib,
  output byte_kind_e        kind
);
  assign func = byte_in[BYTE_W-1:NIB_W];
  assign nib  = byte_in[NIB_W-1:0];

  always_comb begin
    unique case (func)
      FN_POS_PREFIX: kind = BK_POS_PFX;
      FN_NEG_PREFIX: kind = BK_NEG_PFX;
      default:       kind = BK_PLAIN;
    endcase
  end
endmodule

// File: rtl/nibdec_accum.sv
`timescale 1ns/1ps
module nibdec_accum
  import nibdec_pkg::*;
#(
  parameter int OPND_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  byte_kind_e        kind,
  input  logic [NIB_W-1:0]  nib,
  output logic [OPND_W-1:0] merged
);
  localparam int PAD_W = OPND_W - NIB_W;

  logic [OPND_W-1:0] acc_q;
  logic [OPND_W-1:0] acc_d;

  assign merged = acc_q | {{PAD_W{1'b0}}, nib};

  always_comb begin
    unique case (kind)
      BK_POS_PFX: acc_d = merged << NIB_W;
      BK_NEG_PFX: acc_d = (~merged) << NIB_W;
      default:    acc_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       acc_q <= '0;
    else if (step) acc_q <= acc_d;
  end
endmodule

// File: rtl/nibdec_classify.sv
`timescale 1ns/1ps
module nibdec_classify
  import nibdec_pkg::*;
#(
  parameter int OPND_W = 32,
  parameter int SEC_W  = 8
) (
  input  logic [FN_W-1:0]   func,
  input  logic [OPND_W-1:0] operand,
  output logic              is_opr,
  output logic [SEC_W-1:0]  sec_code,
  output logic              sec_illegal
);
  logic too_wide;
  logic [7:0] code8;

  generate
    if (OPND_W > SEC_W) begin : g_wide
      assign too_wide = |operand[OPND_W-1:SEC_W];
    end else begin : g_narrow
      assign too_wide = 1'b0;
    end
    if (SEC_W >= 8) begin : g_code_full
      assign code8 = operand[7:0];
    end else begin : g_code_part
      assign code8 = {{(8-SEC_W){1'b0}}, operand[SEC_W-1:0]};
    end
  endgenerate

  assign is_opr      = (func == FN_OPERATE);
  assign sec_code    = is_opr ? operand[SEC_W-1:0] : '0;
  assign sec_illegal = is_opr && (too_wide || !sec_supported(code8));
endmodule

// File: rtl/nibdec_outreg.sv
`timescale 1ns/1ps
module nibdec_outreg #(
  parameter int REC_W = 46
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [REC_W-1:0] rec_d,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [REC_W-1:0] rec_q,
  output logic             can_take
);
  assign can_take = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      rec_q     <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      rec_q     <= rec_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/nib_prefix_decoder.sv
`timescale 1ns/1ps
module nib_prefix_decoder
  import nibdec_pkg::*;
#(
  parameter int OPND_W = 32,
  parameter int SEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [3:0]        out_func,
  output logic [OPND_W-1:0] out_operand,
  output logic              out_is_opr,
  output logic [SEC_W-1:0]  out_sec_code,
  output logic              out_sec_illegal
);
  localparam int REC_W = FN_W + OPND_W + 1 + SEC_W + 1;

  logic [FN_W-1:0]   func;
  logic [NIB_W-1:0]  nib;
  byte_kind_e        kind;
  logic [OPND_W-1:0] merged;
  logic              is_opr;
  logic [SEC_W-1:0]  sec_code;
  logic              sec_illegal;
  logic              fire;
  logic              emit;
  logic [REC_W-1:0]  rec_d;
  logic [REC_W-1:0]  rec_q;

  nibdec_split u_split (
    .byte_in (in_byte),
    .func    (func),
    .nib     (nib),
    .kind    (kind)
  );

  assign fire = in_valid && in_ready;
  assign emit = fire && (kind == BK_PLAIN);

  nibdec_accum #(.OPND_W(OPND_W)) u_accum (
    .clk    (clk),
    .rst    (rst),
    .step   (fire),
    .kind   (kind),
    .nib    (nib),
    .merged (merged)
  );

  nibdec_classify #(.OPND_W(OPND_W), .SEC_W(SEC_W)) u_class (
    .func        (func),
    .operand     (merged),
    .is_opr      (is_opr),
    .sec_code    (sec_code),
    .sec_illegal (sec_illegal)
  );

  assign rec_d = {func, merged, is_opr, sec_code, sec_illegal};

  nibdec_outreg #(.REC_W(REC_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (emit),
    .rec_d     (rec_d),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .rec_q     (rec_q),
    .can_take  (in_ready)
  );

  assign {out_func, out_operand, out_is_opr, out_sec_code, out_sec_illegal} = rec_q;
endmodule

// File: rtl/nibdec_checks.sv
`timescale 1ns/1ps
module nibdec_checks #(
  parameter int OPND_W = 32,
  parameter int SEC_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [7:0]        in_byte,
  input logic              out_valid,
  input logic              out_ready,
  input logic [3:0]        out_func,
  input logic [OPND_W-1:0] out_operand,
  input logic              out_is_opr,
  input logic [SEC_W-1:0]  out_sec_code,
  input logic              out_sec_illegal
);
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_operand) && $stable(out_func)); // R7
  AST_RESET_DROPS: assert property (@(posedge clk)
    rst |=> !out_valid); // R9
  AST_POS_SILENT: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_byte[7:4] == 4'h2 |=> !out_valid); // R3
  AST_NEG_SILENT: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_byte[7:4] == 4'h6 |=> !out_valid); // R4
  AST_PLAIN_EMITS: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_byte[7:4] != 4'h2 && in_byte[7:4] != 4'h6
    |=> out_valid && out_func == $past(in_byte[7:4])); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid && !out_valid |=> !out_valid); // R8
  AST_WIDE_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_is_opr && (out_operand >> SEC_W) != '0 |-> out_sec_illegal); // R6
  AST_PLAIN_NO_SEC: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_is_opr |-> out_sec_code == '0 && !out_sec_illegal); // R6
endmodule

bind nib_prefix_decoder nibdec_checks #(.OPND_W(OPND_W), .SEC_W(SEC_W)) u_checks (
  .clk             (clk),
  .rst             (rst),
  .in_valid        (in_valid),
  .in_ready        (in_ready),
  .in_byte         (in_byte),
  .out_valid       (out_valid),
  .out_ready       (out_ready),
  .out_func        (out_func),
  .out_operand     (out_operand),
  .out_is_opr      (out_is_opr),
  .out_sec_code    (out_sec_code),
  .out_sec_illegal (out_sec_illegal)
);

// File: tb/nib_prefix_decoder_bench.sv
`timescale 1ns/1ps
module nib_prefix_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_byte = 8'h00;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [3:0]  out_func;
  logic [31:0] out_operand;
  logic        out_is_opr;
  logic [7:0]  out_sec_code;
  logic        out_sec_illegal;

  always #2.5 clk = ~clk;

  nib_prefix_decoder u_nib_prefix_decoder (
    .clk (clk), .rst (rst),
    .in_valid (in_valid), .in_ready (in_ready), .in_byte (in_byte),
    .out_valid (out_valid), .out_ready (out_ready),
    .out_func (out_func), .out_operand (out_operand),
    .out_is_opr (out_is_opr), .out_sec_code (out_sec_code),
    .out_sec_illegal (out_sec_illegal)
  );

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit started = 0;
  bit done = 0;

  // Stimulus knobs
  logic [7:0] stim_q[$];
  bit gaps_on = 0;
  bit bp_on = 0;

  // Reference model state
  bit          m_valid = 0;
  logic [31:0] m_oreg = '0;
  logic [3:0]  m_func = '0;
  logic [31:0] m_opnd = '0;
  bit          took = 0;

  function automatic bit ok_code(input int c);
    if (c <= 16) return 1;
    if (c == 19 || c == 22 || c == 29 || c == 62 || c == 114 || c == 121) return 1;
    if (c >= 25 && c <= 27) return 1;
    if (c >= 31 && c <= 40) return 1;
    if (c == 43 || c == 44) return 1;
    if (c >= 46 && c <= 51) return 1;
    if (c >= 53 && c <= 57) return 1;
    if (c == 59 || c == 60) return 1;
    if (c >= 64 && c <= 79) return 1;
    if (c >= 81 && c <= 83) return 1;
    if (c == 85 || c == 86) return 1;
    if (c == 173 || c == 174) return 1;
    if (c >= 176 && c <= 179) return 1;
    return 0;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // Model update at the clock edge (inputs are stable, driven at negedge)
  always @(posedge clk) begin
    bit acc;
    int n;
    int f;
    cyc++;
    started = 1;
    took = 0;
    if (rst) begin
      m_valid = 0;
      m_oreg = '0;
    end else begin
      acc = in_valid && (!m_valid || out_ready);
      if (m_valid && out_ready) m_valid = 0;
      if (acc) begin
        took = 1;
        n = in_byte[3:0];
        f = in_byte[7:4];
        if (f == 2) m_oreg = (m_oreg | 32'(n)) * 16;
        else if (f == 6) m_oreg = (~(m_oreg | 32'(n))) * 16;
        else begin
          m_valid = 1;
          m_func = 4'(f);
          m_opnd = m_oreg | 32'(n);
          m_oreg = '0;
        end
      end
    end
    if (cyc == 150000 && !done) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // Compare, then drive the next inputs
  always @(negedge clk) begin
    if (started) begin
      chk("R5 R8 R9", "out_valid", out_valid, m_valid);
      chk("R7 R10", "in_ready", in_ready, !m_valid || out_ready);
      if (m_valid) begin
        chk("R1", "func", out_func, m_func);
        chk("R2 R3 R4 R5", "operand", out_operand, m_opnd);
        chk("R6", "is_opr", out_is_opr, m_func == 4'hF);
        chk("R6", "sec_code", out_sec_code, m_func == 4'hF ? m_opnd[7:0] : 8'h0);
        chk("R6", "sec_illegal", out_sec_illegal,
            m_func == 4'hF && (m_opnd > 32'hFF || !ok_code(int'(m_opnd[7:0]))));
      end
    end
    if (took && stim_q.size() > 0) void'(stim_q.pop_front());
    out_ready = bp_on ? ($urandom % 3 != 0) : 1'b1;
    if (stim_q.size() > 0 && !(gaps_on && $urandom % 4 == 0)) begin
      in_valid = 1'b1;
      in_byte = stim_q[0];
    end else begin
      in_valid = 1'b0;
      in_byte = 8'($urandom);   // junk while idle (R8)
    end
  end

  task automatic drain();
    while (stim_q.size() > 0 || m_valid) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;                                        // R9 reset state checked at every negedge
    // R2: plain bytes, no prefix
    stim_q = '{8'h45, 8'h4F, 8'h70, 8'hA3};
    drain();
    // R3: positive prefix chains -> 0x12, 0x1000
    stim_q = '{8'h21, 8'h42, 8'h21, 8'h20, 8'h20, 8'h40};
    drain();
    // R4: negative prefix -> -1 and -0x10
    stim_q = '{8'h60, 8'h4F, 8'h60, 8'h70, 8'h21, 8'h60, 8'h85};
    drain();
    // R6: operate: add, ret (0x20), gap 0x12, wide 0x100, supported 0xB2
    stim_q = '{8'hF5, 8'h22, 8'hF0, 8'h21, 8'hF2, 8'h21, 8'h20, 8'hF0,
               8'h2B, 8'hF2, 8'h60, 8'hF0};
    drain();
    // R9: reset between a prefix and its instruction
    stim_q = '{8'h27};
    while (stim_q.size() > 0) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    stim_q = '{8'h43};
    drain();
    // R7 R8 R10: random stream with gaps and back-pressure
    gaps_on = 1;
    bp_on = 1;
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom % 5;
      if (r == 0) stim_q.push_back({4'h2, 4'($urandom)});
      else if (r == 1) stim_q.push_back({4'h6, 4'($urandom)});
      else if (r == 2) stim_q.push_back({4'hF, 4'($urandom)});
      else stim_q.push_back(8'($urandom));
    end
    drain();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule